// File: doc/BRIEF.md
# Horizontal Raster Position Counter with Retrace Jump

This block produces the horizontal pixel position for a raster video timing generator. It advances by one on every pixel-clock enable. Its sequence is not contiguous. Partway through each line, after the last visible position, the count jumps to a high reload value. It then climbs to the top of the 8-bit range and wraps to zero. Because of this, small values always mean the visible part of the line and high values always mean retrace. Software reading the position can tell the two apart at a glance.

Two line widths are supported. Each has its own jump point and reload value, so each produces its own line length. The width select is taken only when the count wraps, so a line is never mixed between two widths. A one-clock pulse marks the start of each line. A horizontal-blank flag is decoded from the position. It rises some pixels before the end of the visible region, which is ahead of where a downstream sync shaper would begin its pulse.

Top module: `hraster_hcounter`

## Requirements
- R1: While reset is low, and on the first clock after it is released, the count is 0x00 and the line-wrap pulse is low. The blank flag is high, and the current line uses the narrow width.
- R2: The count, the blank flag and the line-wrap pulse change only on a rising clock edge at which the pixel enable is high. On any other edge the count and blank flag hold and the line-wrap pulse is low.
- R3: In the narrow width (wideMode = 0) the count runs 0x00, 0x01, ... 0x93, then 0xE9, 0xEA, ... 0xFF. That is 171 pixel steps per line.
- R4: In the wide width (wideMode = 1) the count runs 0x00, ... 0xB6, then 0xE4, ... 0xFF. That is 211 pixel steps per line.
- R5: An enabled step from 0xFF always gives 0x00, in either width.
- R6: The line-wrap output is high for exactly one clock: the clock that follows the edge on which the count went from 0xFF to 0x00. It is never high at any other time, including after reset.
- R7: wideMode is sampled only on the enabled step from 0xFF to 0x00. A change during a line does not alter that line's jump point, reload value or blank window.
- R8: In the narrow width the blank flag is high for counts at or above 0x80 and for counts below 0x10. That is 59 pixels per line, or 590 master clocks at 10 master clocks per pixel.
- R9: In the wide width the blank flag is high for counts at or above 0xA6 and for counts below 0x0B, which is 56 pixels per line. The flag updates on the same edge as the count. It uses the width of the line that the new count belongs to.
- R10: Counts strictly between 0xB6 and 0xE4 never appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixEn | input | 1 | Pixel-clock enable, one master clock wide |
| wideMode | input | 1 | Width select for the next line: 1 = wide, 0 = narrow |
| hCount | output | 8 | Horizontal position |
| lineWrap | output | 1 | One-clock pulse at the start of each line |
| hBlank | output | 1 | Horizontal-blank flag |

## Verification
A wrong latched width shows up at the next jump point. The count lands on the other width's reload value, or runs past 0x93 or 0xB6, within one line, and the line-length tally differs by 40 pixels. A wrong count register shows up on the very next enabled step, because every step is compared with a reference position. A misplaced blank decode shows up as a blank flag that disagrees on a single position, and as a per-line blank tally other than 59 or 56.

// File: rtl/hcnt_pkg.sv
package hcnt_pkg;

  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic advance;   // step this clock
    logic jump;      // load the reload value instead of +1
    logic wrap;      // last position of the line: go to zero
    logic wideNext;  // width of the line the next count belongs to
  } hcnt_strobe_t;

endpackage

// File: rtl/hcnt_ctrl.sv
module hcnt_ctrl
  import hcnt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] NARROW_TERM = 8'h93,
  parameter logic [CNT_W-1:0] WIDE_TERM   = 8'hB6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixEn,
  input  logic             wideMode,
  input  logic [CNT_W-1:0] count,
  output hcnt_strobe_t     strobe
);

  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic             modeQ;
  logic [CNT_W-1:0] termVal;

  always_comb begin
    termVal         = modeQ ? WIDE_TERM : NARROW_TERM;
    strobe.advance  = pixEn;
    strobe.wrap     = pixEn && (count == CNT_LAST);
    strobe.jump     = pixEn && (count == termVal);
    strobe.wideNext = strobe.wrap ? wideMode : modeQ;
  end

  // The width is latched only when the line wraps.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= strobe.wideNext;
  end

endmodule

// File: rtl/hcnt_datapath.sv
module hcnt_datapath
  import hcnt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] NARROW_RELOAD    = 8'hE9,
  parameter logic [CNT_W-1:0] WIDE_RELOAD      = 8'hE4,
  parameter logic [CNT_W-1:0] NARROW_BLANK_ON  = 8'h80,
  parameter logic [CNT_W-1:0] NARROW_BLANK_OFF = 8'h10,
  parameter logic [CNT_W-1:0] WIDE_BLANK_ON    = 8'hA6,
  parameter logic [CNT_W-1:0] WIDE_BLANK_OFF   = 8'h0B
) (
  input  logic             clk,
  input  logic             rstN,
  input  hcnt_strobe_t     strobe,
  output logic [CNT_W-1:0] count,
  output logic             hBlank,
  output logic             lineWrap
);

  logic [CNT_W-1:0] nextCount;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] blankOn;
  logic [CNT_W-1:0] blankOff;
  logic             nextBlank;

  always_comb begin
    // wideNext equals the current line width except on the wrap step.
    reloadVal = strobe.wideNext ? WIDE_RELOAD : NARROW_RELOAD;
    if (strobe.wrap)         nextCount = '0;
    else if (strobe.jump)    nextCount = reloadVal;
    else if (strobe.advance) nextCount = count + 1'b1;
    else                     nextCount = count;

    blankOn   = strobe.wideNext ? WIDE_BLANK_ON  : NARROW_BLANK_ON;
    blankOff  = strobe.wideNext ? WIDE_BLANK_OFF : NARROW_BLANK_OFF;
    nextBlank = (nextCount >= blankOn) || (nextCount < blankOff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      hBlank   <= 1'b1;
      lineWrap <= 1'b0;
    end else begin
      count    <= nextCount;
      hBlank   <= nextBlank;
      lineWrap <= strobe.wrap;
    end
  end

endmodule

// File: rtl/hraster_hcounter.sv
module hraster_hcounter
  import hcnt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] NARROW_TERM      = 8'h93,
  parameter logic [CNT_W-1:0] NARROW_RELOAD    = 8'hE9,
  parameter logic [CNT_W-1:0] WIDE_TERM        = 8'hB6,
  parameter logic [CNT_W-1:0] WIDE_RELOAD      = 8'hE4,
  parameter logic [CNT_W-1:0] NARROW_BLANK_ON  = 8'h80,
  parameter logic [CNT_W-1:0] NARROW_BLANK_OFF = 8'h10,
  parameter logic [CNT_W-1:0] WIDE_BLANK_ON    = 8'hA6,
  parameter logic [CNT_W-1:0] WIDE_BLANK_OFF   = 8'h0B
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixEn,
  input  logic             wideMode,
  output logic [CNT_W-1:0] hCount,
  output logic             lineWrap,
  output logic             hBlank
);

  hcnt_strobe_t strobe;

  hcnt_ctrl #(
    .CNT_W(CNT_W),
    .NARROW_TERM(NARROW_TERM),
    .WIDE_TERM(WIDE_TERM)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .pixEn(pixEn),
    .wideMode(wideMode),
    .count(hCount),
    .strobe(strobe)
  );

  hcnt_datapath #(
    .CNT_W(CNT_W),
    .NARROW_RELOAD(NARROW_RELOAD),
    .WIDE_RELOAD(WIDE_RELOAD),
    .NARROW_BLANK_ON(NARROW_BLANK_ON),
    .NARROW_BLANK_OFF(NARROW_BLANK_OFF),
    .WIDE_BLANK_ON(WIDE_BLANK_ON),
    .WIDE_BLANK_OFF(WIDE_BLANK_OFF)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .count(hCount),
    .hBlank(hBlank),
    .lineWrap(lineWrap)
  );

endmodule

// File: rtl/hcnt_checker.sv
module hcnt_checker #(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] NARROW_TERM   = 8'h93,
  parameter logic [CNT_W-1:0] NARROW_RELOAD = 8'hE9,
  parameter logic [CNT_W-1:0] WIDE_TERM     = 8'hB6,
  parameter logic [CNT_W-1:0] WIDE_RELOAD   = 8'hE4
) (
  input logic             clk,
  input logic             rstN,
  input logic             pixEn,
  input logic [CNT_W-1:0] hCount,
  input logic             lineWrap,
  input logic             hBlank
);

  localparam logic [CNT_W-1:0] CNT_LAST     = '1;
  localparam logic [CNT_W-1:0] NARROW_AFTER = NARROW_TERM + 1'b1;
  localparam logic [CNT_W-1:0] WIDE_AFTER   = WIDE_TERM + 1'b1;
  localparam logic [CNT_W-1:0] TERM_MAX     = (NARROW_TERM > WIDE_TERM) ? NARROW_TERM : WIDE_TERM;
  localparam logic [CNT_W-1:0] RELOAD_MIN   = (NARROW_RELOAD < WIDE_RELOAD) ? NARROW_RELOAD : WIDE_RELOAD;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> ($stable(hCount) && $stable(hBlank) && !lineWrap));

  assert_narrow_jump_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && hCount == NARROW_TERM) |=> (hCount == NARROW_AFTER || hCount == NARROW_RELOAD));

  assert_wide_jump_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && hCount == WIDE_TERM) |=> (hCount == WIDE_AFTER || hCount == WIDE_RELOAD));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && hCount == CNT_LAST) |=> (hCount == '0 && lineWrap));

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    lineWrap |=> !lineWrap);

  assert_pulse_at_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    lineWrap |-> (hCount == '0));

  // Both widths blank position zero (R8 and R9).
  assert_blank_at_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hCount == '0) |-> hBlank);

  assert_no_gap_value_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hCount <= TERM_MAX) || (hCount >= RELOAD_MIN));

endmodule

bind hraster_hcounter hcnt_checker #(
  .CNT_W(CNT_W),
  .NARROW_TERM(NARROW_TERM),
  .NARROW_RELOAD(NARROW_RELOAD),
  .WIDE_TERM(WIDE_TERM),
  .WIDE_RELOAD(WIDE_RELOAD)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .pixEn(pixEn),
  .hCount(hCount),
  .lineWrap(lineWrap),
  .hBlank(hBlank)
);

// File: tb/hraster_hcounter_tb.sv
module hraster_hcounter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixEn = 1'b0;
  logic       wideMode = 1'b0;
  logic [7:0] hCount;
  logic       lineWrap;
  logic       hBlank;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [7:0] expCount = 8'h00;
  bit         expWide = 0;
  bit         expWrap = 0;
  bit         expBlank = 1;
  int         linePix = 0;
  int         lineBlank = 0;
  int         divCnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  hraster_hcounter u_dut (
    .clk(clk),
    .rstN(rstN),
    .pixEn(pixEn),
    .wideMode(wideMode),
    .hCount(hCount),
    .lineWrap(lineWrap),
    .hBlank(hBlank)
  );

  function automatic logic [7:0] refNext(input logic [7:0] c, input bit w);
    if (c == 8'hFF) return 8'h00;
    if (!w && c == 8'h93) return 8'hE9;
    if (w && c == 8'hB6) return 8'hE4;
    return c + 8'h01;
  endfunction

  function automatic bit refBlank(input logic [7:0] c, input bit w);
    if (w) return (c >= 8'hA6) || (c < 8'h0B);
    return (c >= 8'h80) || (c < 8'h10);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Called just after a falling edge: drive inputs, advance the reference,
  // wait one clock and compare at the next falling edge.
  task automatic stepCycle(input bit pe, input bit wm);
    bit wrapping;
    bit oldWide;
    pixEn = pe;
    wideMode = wm;
    oldWide = expWide;
    wrapping = pe && (expCount == 8'hFF);
    if (pe) begin
      linePix++;
      if (expBlank) lineBlank++;
      expCount = refNext(expCount, expWide);
      if (wrapping) expWide = wm;
    end
    expWrap = wrapping;
    expBlank = refBlank(expCount, expWide);
    @(negedge clk);
    chk(hCount == expCount, oldWide ? "R4 count" : "R3 count", hCount, expCount);
    chk(lineWrap == expWrap, pe ? "R6 wrap pulse" : "R2 wrap idle", lineWrap, expWrap);
    chk(hBlank == expBlank, expWide ? "R9 blank" : "R8 blank", hBlank, expBlank);
    chk((hCount <= 8'hB6) || (hCount >= 8'hE4), "R10 gap value", hCount, 0);
    if (wrapping) begin
      if (oldWide) begin
        chk(linePix == 211, "R4 line length", linePix, 211);
        chk(lineBlank == 56, "R9 blank pixels", lineBlank, 56);
      end else begin
        chk(linePix == 171, "R3 line length", linePix, 171);
        chk(lineBlank == 59, "R8 blank pixels", lineBlank * 10, 590);
      end
      linePix = 0;
      lineBlank = 0;
    end
  endtask

  // Pixel enable at a fixed cadence: 10 master clocks narrow, 8 wide.
  task automatic stepDiv(input bit wm);
    int period;
    bit pe;
    period = expWide ? 8 : 10;
    pe = (divCnt == 0);
    divCnt = (divCnt + 1 >= period) ? 0 : divCnt + 1;
    stepCycle(pe, wm);
  endtask

  task automatic resetModel();
    expCount = 8'h00;
    expWide = 0;
    expWrap = 0;
    expBlank = 1;
    linePix = 0;
    lineBlank = 0;
    divCnt = 0;
  endtask

  task automatic checkReset(input string tag);
    chk(hCount == 8'h00, tag, hCount, 0);
    chk(lineWrap == 1'b0, tag, lineWrap, 0);
    chk(hBlank == 1'b1, tag, hBlank, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0h expected=%0h", hCount, 0);
      finishRun();
    end
  end

  initial begin
    bit wm;
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    repeat (3) @(negedge clk);
    checkReset("R1 during reset");
    rstN = 1'b1;
    resetModel();
    stepCycle(1'b0, 1'b0);
    checkReset("R1 after release");

    // Narrow lines, with a width change requested mid-line (R7)
    for (int i = 0; i < 2 * 1710; i++) stepDiv(1'b0);
    while (expCount != 8'h50) stepDiv(1'b0);
    while (expCount != 8'h93) stepDiv(1'b1);
    while (expCount == 8'h93) stepDiv(1'b1);
    chk(hCount == 8'hE9, "R7 mid-line width change ignored", hCount, 8'hE9);
    while (!expWrap) stepDiv(1'b1);
    chk(hCount == 8'h00 && lineWrap, "R5 wrap to zero", hCount, 0);
    for (int i = 0; i < 3 * 1688; i++) stepDiv(1'b1);

    // Random width requests at the regular cadence
    wm = 1'b1;
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 599) == 0) wm = ~wm;
      stepDiv(wm);
    end

    // Irregular pixel enable, including back-to-back enables
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 399) == 0) wm = ~wm;
      stepCycle($urandom_range(0, 2) == 0, wm);
    end

    // Mid-line reset
    while (expCount < 8'h30 || expCount > 8'h90) stepDiv(wm);
    rstN = 1'b0;
    pixEn = 1'b1;
    @(negedge clk);
    checkReset("R1 mid-line reset");
    pixEn = 1'b0;
    rstN = 1'b1;
    resetModel();
    stepCycle(1'b0, 1'b1);
    checkReset("R1 after second release");
    for (int i = 0; i < 1710 + 1688 + 20; i++) stepDiv(1'b1);

    finishRun();
  end

endmodule